// File: doc/BRIEF.md
# Chunked Interrupt Identifier Allocator

This block hands out ranges of interrupt identifiers taken from a pool that begins just above a reserved region of 8192 identifiers. The pool is divided into chunks of 32 identifiers. One occupancy bit per chunk records which chunks are held. An allocation request carries a vector count. The block looks for the lowest run of free chunks long enough to cover it and marks that run as held. It returns the first identifier of the run and the number of identifiers granted. If no run is long enough, the wanted length shrinks by one chunk and the search starts again from the lowest chunk. The caller can therefore receive fewer identifiers than it asked for. The request fails only when not even one chunk is free.

A release request carries a base identifier and a count. The block steps from the base in strides of 32 and clears the bit of each chunk it lands on. If a step lands on a chunk that is not held, or outside the pool, the response reports an error and that chunk is left alone.

Only one operation runs at a time. The search examines one chunk per clock. A busy output covers the whole operation, and a one-cycle response pulse ends it. The pool size follows from the identifier width: (2^ID_BITS − 8192) / 32 chunks, which is 256 chunks with the default width of 14.

Top module: `chunk_id_alloc`

## Requirements
- R1: After reset every chunk is free, `busy` is low and `rsp_valid` is low.
- R2: The wanted chunk count is the vector count divided by 32, rounded up. An allocation with a vector count of 0 is answered with `rsp_ok` low in the cycle after acceptance and never raises `busy`.
- R3: A successful allocation grants the lowest-index run of free chunks of the current length. It answers with `rsp_ok` high, `rsp_base` = 8192 + 32 × first chunk and `rsp_count` = 32 × run length.
- R4: When no run of the current length exists, the length drops by one and the search restarts at chunk 0. When no single free chunk exists, the answer is `rsp_ok` low with `rsp_base` and `rsp_count` zero. A wanted length above the pool size is first cut to the pool size.
- R5: Granted chunks are marked held and are not granted again until released.
- R6: A release makes ceil(count / 32) steps, starting at `req_base` and adding 32 per step. Each step clears the held chunk (id − 8192) >> 5. The answer has `rsp_ok` high when every step hit a held chunk. A count of 0 is answered with `rsp_ok` high in the cycle after acceptance.
- R7: A release step on a chunk that is not held answers `rsp_ok` low and changes no chunk.
- R8: A release step whose identifier is below 8192, or whose chunk index is at or above the pool size, answers `rsp_ok` low and changes no chunk. The other steps of the same release still take effect.
- R9: An operation of n chunk examinations or release steps holds `busy` high for n cycles after the acceptance edge. `rsp_valid` pulses for one cycle as `busy` falls, and `busy` is never high while `rsp_valid` is high. On a release answer, `rsp_base` and `rsp_count` are zero.
- R10: A request presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe; taken when `busy` is low |
| req_free | input | 1 | 1 = release, 0 = allocate |
| req_base | input | ID_BITS | First identifier to release |
| req_count | input | ID_BITS+1 | Vector count (allocate) or identifier count (release) |
| busy | output | 1 | An operation is in progress |
| rsp_valid | output | 1 | One-cycle answer strobe |
| rsp_ok | output | 1 | Grant made / release clean |
| rsp_base | output | ID_BITS | First granted identifier, else 0 |
| rsp_count | output | ID_BITS+1 | Number of granted identifiers, else 0 |

## Verification
The occupancy bits are visible only through later grants. A wrongly set or cleared bit shows up at the next allocation whose first-fit scan crosses that chunk: the grant lands at another base, or the search takes a different number of cycles. That difference appears on the cycle when `busy` falls. The bench therefore compares `busy` and `rsp_valid` on every cycle of every operation. Its sequence of grants, shrinks and releases walks first-fit placement over holes of known size, so a lost or stray bit changes either the answer fields or the length of the busy window. A step counter or scan pointer that is off by one shows at once as a busy window of the wrong length.

// File: rtl/idalloc_pkg.sv
package idalloc_pkg;
  localparam int unsigned RSV_IDS     = 8192;
  localparam int unsigned CHUNK_SHIFT = 5;
  localparam int unsigned CHUNK_IDS   = 1 << CHUNK_SHIFT;

  // pool size in chunks for a given identifier width
  function automatic int unsigned pool_chunks(input int unsigned id_bits);
    return ((1 << id_bits) - RSV_IDS) >> CHUNK_SHIFT;
  endfunction

  // chunks needed to cover a vector count, rounded up
  function automatic int unsigned chunks_for(input int unsigned vecs);
    return (vecs + CHUNK_IDS - 1) >> CHUNK_SHIFT;
  endfunction

  // first identifier of a chunk
  function automatic int unsigned chunk_first_id(input int unsigned chunk);
    return (chunk << CHUNK_SHIFT) + RSV_IDS;
  endfunction

  // identifiers covered by a run of chunks
  function automatic int unsigned run_ids(input int unsigned run_len);
    return run_len << CHUNK_SHIFT;
  endfunction
endpackage

// File: rtl/idalloc_map.sv
module idalloc_map #(
  parameter int NCHUNK = 256,
  parameter int IDX_W  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_lo,
  input  logic [IDX_W-1:0] set_hi,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_used
);
  logic [NCHUNK-1:0] used;

  for (genvar g = 0; g < NCHUNK; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        used[g] <= 1'b0;
      else if (set_en && IDX_W'(g) >= set_lo && IDX_W'(g) <= set_hi)
        used[g] <= 1'b1;
      else if (clr_en && clr_idx == IDX_W'(g))
        used[g] <= 1'b0;
    end
  end

  // index past the pool reads as held
  always_comb begin
    rd_used = 1'b1;
    for (int i = 0; i < NCHUNK; i++)
      if (rd_idx == IDX_W'(i)) rd_used = used[i];
  end
endmodule

// File: rtl/idalloc_scan.sv
module idalloc_scan #(
  parameter int NCHUNK = 256,
  parameter int IDX_W  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] start_len,
  input  logic             cur_used,
  output logic             active,
  output logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] len,
  output logic [IDX_W-1:0] run_lo,
  output logic             hit,
  output logic             give_up
);
  logic [IDX_W-1:0] run;
  logic             wrap;

  assign hit     = active && !cur_used && (run + IDX_W'(1) == len);
  assign wrap    = active && !hit && (idx == IDX_W'(NCHUNK - 1));
  assign give_up = wrap && (len == IDX_W'(1));
  assign run_lo  = idx - len + IDX_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      run    <= '0;
      len    <= '0;
    end else if (start) begin
      active <= 1'b1;
      idx    <= '0;
      run    <= '0;
      len    <= start_len;
    end else if (active) begin
      if (hit || give_up) begin
        active <= 1'b0;
      end else if (wrap) begin
        len <= len - IDX_W'(1);
        idx <= '0;
        run <= '0;
      end else begin
        idx <= idx + IDX_W'(1);
        run <= cur_used ? '0 : run + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/idalloc_walk.sv
module idalloc_walk
  import idalloc_pkg::*;
#(
  parameter int ID_BITS = 14,
  parameter int NCHUNK  = 256,
  parameter int IDX_W   = 9,
  parameter int STEP_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ID_BITS-1:0] start_id,
  input  logic [STEP_W-1:0]  steps,
  output logic               active,
  output logic [IDX_W-1:0]   chunk,
  output logic               in_range,
  output logic               last
);
  localparam int WID_W = ID_BITS + 2;
  localparam logic [WID_W-1:0] LO_ID = WID_W'(RSV_IDS);
  localparam logic [WID_W-1:0] HI_ID = WID_W'(RSV_IDS + NCHUNK * CHUNK_IDS);

  logic [WID_W-1:0]  cur;
  logic [WID_W-1:0]  off;
  logic [STEP_W-1:0] left;

  assign off      = cur - LO_ID;
  assign in_range = (cur >= LO_ID) && (cur < HI_ID);
  assign chunk    = IDX_W'(off >> CHUNK_SHIFT);
  assign last     = active && (left == STEP_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cur    <= '0;
      left   <= '0;
    end else if (start) begin
      active <= 1'b1;
      cur    <= WID_W'(start_id);
      left   <= steps;
    end else if (active) begin
      cur  <= cur + WID_W'(CHUNK_IDS);
      left <= left - STEP_W'(1);
      if (last) active <= 1'b0;
    end
  end
endmodule

// File: rtl/chunk_id_alloc.sv
module chunk_id_alloc
  import idalloc_pkg::*;
#(
  parameter int ID_BITS = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_free,
  input  logic [ID_BITS-1:0] req_base,
  input  logic [ID_BITS:0]   req_count,
  output logic               busy,
  output logic               rsp_valid,
  output logic               rsp_ok,
  output logic [ID_BITS-1:0] rsp_base,
  output logic [ID_BITS:0]   rsp_count
);
  localparam int NCHUNK = int'(pool_chunks(ID_BITS));
  localparam int IDX_W  = $clog2(NCHUNK + 1);
  localparam int CNT_W  = ID_BITS + 1;
  localparam int STEP_W = CNT_W + 1;

  // internal events, named for the checker
  logic               accept, alloc_go, alloc_nil, free_go, free_nil;
  logic [STEP_W-1:0]  req_chunks;
  logic [IDX_W-1:0]   start_len;
  logic               scan_active, scan_hit, scan_give_up;
  logic [IDX_W-1:0]   scan_idx, scan_len, scan_run_lo;
  logic               walk_active, walk_in_range, walk_last;
  logic [IDX_W-1:0]   walk_chunk;
  logic [IDX_W-1:0]   rd_idx;
  logic               cur_used;
  logic               clr_en, step_bad, free_bad;

  assign req_chunks = STEP_W'(chunks_for(32'(req_count)));
  assign start_len  = (req_chunks > STEP_W'(NCHUNK)) ? IDX_W'(NCHUNK) : IDX_W'(req_chunks);

  assign busy      = scan_active || walk_active;
  assign accept    = req_valid && !busy;
  assign alloc_go  = accept && !req_free && (req_chunks != '0);
  assign alloc_nil = accept && !req_free && (req_chunks == '0);
  assign free_go   = accept && req_free && (req_chunks != '0);
  assign free_nil  = accept && req_free && (req_chunks == '0);

  assign rd_idx   = scan_active ? scan_idx : walk_chunk;
  assign clr_en   = walk_active && walk_in_range && cur_used;
  assign step_bad = walk_active && !(walk_in_range && cur_used);

  idalloc_map #(.NCHUNK(NCHUNK), .IDX_W(IDX_W)) u_map (
    .clk(clk), .rst_n(rst_n),
    .set_en(scan_hit), .set_lo(scan_run_lo), .set_hi(scan_idx),
    .clr_en(clr_en), .clr_idx(walk_chunk),
    .rd_idx(rd_idx), .rd_used(cur_used)
  );

  idalloc_scan #(.NCHUNK(NCHUNK), .IDX_W(IDX_W)) u_scan (
    .clk(clk), .rst_n(rst_n),
    .start(alloc_go), .start_len(start_len), .cur_used(cur_used),
    .active(scan_active), .idx(scan_idx), .len(scan_len),
    .run_lo(scan_run_lo), .hit(scan_hit), .give_up(scan_give_up)
  );

  idalloc_walk #(.ID_BITS(ID_BITS), .NCHUNK(NCHUNK), .IDX_W(IDX_W), .STEP_W(STEP_W)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .start(free_go), .start_id(req_base), .steps(req_chunks),
    .active(walk_active), .chunk(walk_chunk), .in_range(walk_in_range), .last(walk_last)
  );

  // sticky release error
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        free_bad <= 1'b0;
    else if (free_go)  free_bad <= 1'b0;
    else if (step_bad) free_bad <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_base  <= '0;
      rsp_count <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (alloc_nil || scan_give_up) begin
        rsp_valid <= 1'b1;
        rsp_ok    <= 1'b0;
        rsp_base  <= '0;
        rsp_count <= '0;
      end else if (free_nil) begin
        rsp_valid <= 1'b1;
        rsp_ok    <= 1'b1;
        rsp_base  <= '0;
        rsp_count <= '0;
      end else if (scan_hit) begin
        rsp_valid <= 1'b1;
        rsp_ok    <= 1'b1;
        rsp_base  <= ID_BITS'(chunk_first_id(32'(scan_run_lo)));
        rsp_count <= CNT_W'(run_ids(32'(scan_len)));
      end else if (walk_last) begin
        rsp_valid <= 1'b1;
        rsp_ok    <= !(free_bad || step_bad);
        rsp_base  <= '0;
        rsp_count <= '0;
      end
    end
  end
endmodule

// File: rtl/idalloc_chk.sv
module idalloc_chk
  import idalloc_pkg::*;
#(
  parameter int ID_BITS = 14
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               rsp_valid,
  input logic               rsp_ok,
  input logic [ID_BITS-1:0] rsp_base,
  input logic [ID_BITS:0]   rsp_count,
  input logic               scan_active,
  input logic               walk_active,
  input logic               scan_hit
);
  // R9: an answer never overlaps a running operation
  p_resp_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !busy);

  // R9: the end of every busy window carries an answer
  p_fall_answers_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rsp_valid);

  // R10: search and release never run together
  p_serial_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scan_active, walk_active}));

  // R3: a grant is chunk-aligned, above the reserved region, a multiple of 32
  p_grant_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_count != '0) |->
      (rsp_ok && rsp_base[CHUNK_SHIFT-1:0] == '0 &&
       rsp_base >= ID_BITS'(RSV_IDS) && rsp_count[CHUNK_SHIFT-1:0] == '0));

  // R4: a failed answer carries no range
  p_fail_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ok) |-> (rsp_count == '0 && rsp_base == '0));

  // R5: a found run is reported as a grant on the next cycle
  p_hit_grants_r5: assert property (@(posedge clk) disable iff (!rst_n)
    scan_hit |=> (rsp_valid && rsp_ok && rsp_count != '0));
endmodule

bind chunk_id_alloc idalloc_chk #(.ID_BITS(ID_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rsp_valid(rsp_valid),
  .rsp_ok(rsp_ok), .rsp_base(rsp_base), .rsp_count(rsp_count),
  .scan_active(scan_active), .walk_active(walk_active), .scan_hit(scan_hit)
);

// File: tb/tb_chunk_id_alloc.sv
`timescale 1ns/1ps
module tb_chunk_id_alloc;
  localparam int ID_BITS = 14;
  localparam int NCH     = ((1 << ID_BITS) - 8192) / 32;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               req_valid = 1'b0;
  logic               req_free = 1'b0;
  logic [ID_BITS-1:0] req_base = '0;
  logic [ID_BITS:0]   req_count = '0;
  logic               busy, rsp_valid, rsp_ok;
  logic [ID_BITS-1:0] rsp_base;
  logic [ID_BITS:0]   rsp_count;

  int checks = 0;
  int errors = 0;
  bit held [NCH];

  always #2.5 clk = ~clk;

  chunk_id_alloc #(.ID_BITS(ID_BITS)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_free(req_free),
    .req_base(req_base), .req_count(req_count), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_base(rsp_base), .rsp_count(rsp_count)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference: first-fit with shrinking, counting examined chunks
  task automatic model_alloc(input int vecs, output int n, output int ok,
                             output int base, output int cnt);
    int want = (vecs + 31) / 32;
    if (want > NCH) want = NCH;
    n = 0; ok = 0; base = 0; cnt = 0;
    for (int l = want; l >= 1 && ok == 0; l--) begin
      int found = -1;
      for (int s = 0; s + l <= NCH && found < 0; s++) begin
        bit clear = 1'b1;
        for (int j = 0; j < l; j++) if (held[s + j]) clear = 1'b0;
        if (clear) found = s;
      end
      if (found >= 0) begin
        n += found + l;
        for (int j = 0; j < l; j++) held[found + j] = 1'b1;
        ok = 1; base = 8192 + 32 * found; cnt = 32 * l;
      end else begin
        n += NCH;
      end
    end
  endtask

  task automatic model_free(input int base, input int count, output int n, output int ok);
    n = (count + 31) / 32;
    ok = 1;
    for (int k = 0; k < n; k++) begin
      int id = base + 32 * k;
      if (id < 8192 || (id - 8192) / 32 >= NCH) ok = 0;
      else if (!held[(id - 8192) / 32]) ok = 0;
      else held[(id - 8192) / 32] = 1'b0;
    end
  endtask

  // issue one operation at a negedge; compare every cycle until the answer
  task automatic run_op(input bit is_free, input int base, input int count,
                        input bit inject, input string req);
    int n, ok, ebase, ecnt;
    if (is_free) begin
      model_free(base, count, n, ok);
      ebase = 0; ecnt = 0;
    end else begin
      model_alloc(count, n, ok, ebase, ecnt);
    end
    req_valid = 1'b1; req_free = is_free;
    req_base = ID_BITS'(base); req_count = (ID_BITS+1)'(count);
    @(posedge clk); #1;
    req_valid = 1'b0;
    for (int k = 0; k <= n; k++) begin
      @(negedge clk);
      if (inject && k == 2) req_valid = 1'b0;
      chk("R9", "busy", int'(busy), (k < n) ? 1 : 0);
      chk("R9", "rsp_valid", int'(rsp_valid), (k == n) ? 1 : 0);
      if (k == n) begin
        chk(req, "rsp_ok", int'(rsp_ok), ok);
        chk(req, "rsp_base", int'(rsp_base), ebase);
        chk(req, "rsp_count", int'(rsp_count), ecnt);
      end
      if (inject && k == 1) begin
        // R10: a release of the whole pool while busy must be ignored
        req_valid = 1'b1; req_free = 1'b1; req_base = ID_BITS'(8192);
        req_count = (ID_BITS+1)'(8192);
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual %0d expected %0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "rsp_valid after reset", int'(rsp_valid), 0);

    run_op(0, 0, 0, 0, "R2");        // zero vectors: immediate failure
    run_op(0, 0, 1, 0, "R2");        // chunk 0
    run_op(0, 0, 33, 0, "R2");       // rounds up to 2 chunks: 1-2
    run_op(0, 0, 100, 1, "R10");     // 4 chunks 3-6, ignored request injected
    run_op(1, 8224, 64, 0, "R6");    // release chunks 1-2
    run_op(0, 0, 40, 0, "R3");       // first fit back at chunk 1
    run_op(0, 0, 1, 0, "R5");        // chunks 0-6 held: chunk 7
    run_op(1, 8416, 32, 0, "R6");    // release chunk 7
    run_op(1, 8416, 32, 0, "R7");    // second release: error
    run_op(0, 0, 1, 0, "R7");        // chunk 7 free again, unchanged
    run_op(1, 8000, 256, 0, "R8");   // steps below 8192 rejected, 0-1 cleared
    run_op(1, 9000, 0, 0, "R6");     // zero count: immediate clean answer
    run_op(0, 0, 8000, 0, "R4");     // 250 wanted, shrinks to 248 at chunk 8
    run_op(0, 0, 96, 0, "R4");       // 3 wanted, shrinks to 2 at chunk 0
    run_op(0, 0, 1, 0, "R4");        // pool full: failure
    run_op(1, 16352, 64, 0, "R8");   // chunk 255 cleared, step past pool rejected
    run_op(0, 0, 1, 0, "R8");        // only chunk 255 was freed
    run_op(1, 8192, 8192, 0, "R6");  // release whole pool, all held
    run_op(0, 0, 32767, 0, "R4");    // capped to pool size: full grant
    run_op(0, 0, 1, 0, "R5");        // nothing left

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule